// File: doc/BRIEF.md
# Serial Keyboard Command Responder

This block is the device end of a serial keyboard on one channel of a serial port. The host sends command bytes to it. The block answers some commands with short fixed response sequences, and it turns make/break key events into key-code bytes. Every byte it produces goes into a small receive FIFO, and the host drains that FIFO one byte per read. The receive-available flag stays raised while the FIFO holds bytes.

Key codes arrive already translated to 7-bit values. A press is queued with bit 7 clear and a release with bit 7 set. Some keys are marked as lock keys. Each lock key has a 2-bit toggle state, so the host sees one press when the lock turns on and one release when it turns off. The other press/release edges of that key are dropped.

A command and a key event can arrive in the same cycle, together with a host read. The FIFO accepts up to four bytes per cycle, so nothing ever stalls.

Top module: `kbd_responder`

## Requirements
- R1: After reset the FIFO is empty, `rx_avail_o` is 0, `rd_data_o` is 0, the LED-skip state is clear and every lock-key state is 0.
- R2: Host byte 0x01 discards all queued bytes and then queues 0xFF, 0x04, 0x7F, in that order.
- R3: Host byte 0x0E queues nothing. The next host byte is consumed without effect, whatever its value. The byte after that is decoded normally.
- R4: Host byte 0x07 or 0x0F discards all queued bytes and then queues 0xFE followed by the layout code.
- R5: The layout code is `layout_i`. When `layout_i` is 0xFF (not configured), the layout code is the parameter `DEF_LAYOUT`, which defaults to 0x21.
- R6: A key event on a key that is not a lock key queues `{~key_down_i, key_code_i}`. A press therefore has bit 7 clear and a release has bit 7 set.
- R7: A lock key event updates that key's 2-bit state. A press XORs the state with 1 and is dropped if the new state is 2. A release XORs the state with 2 and is dropped if the new state is 3. A lock event that is not dropped queues the byte R6 describes.
- R8: When the FIFO holds 16 bytes, any further byte is discarded. When several bytes arrive at once, they are accepted in order until the FIFO is full.
- R9: A read of an empty FIFO returns 0 on `rd_data_o` and changes nothing.
- R10: `rx_avail_o` is 1 exactly when the FIFO holds at least one byte. This includes the case where a read leaves bytes behind.
- R11: Any other host byte, when the LED-skip state is clear, changes nothing.
- R12: In a single cycle the order is: the read takes the old head first, then any discard, then the command's response bytes, then the key byte.
- R13: Bytes are read out in the order they were queued, across pointer wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_wr_i | input | 1 | Host command byte strobe |
| host_data_i | input | 8 | Host command byte |
| layout_i | input | 8 | Configured layout code, 0xFF when unset |
| key_evt_i | input | 1 | Key event strobe |
| key_down_i | input | 1 | 1 for press, 0 for release |
| key_code_i | input | 7 | Translated key code |
| key_lock_i | input | 1 | Event belongs to a lock key |
| key_lock_idx_i | input | LOCK_IDX_W | Which lock key |
| rd_i | input | 1 | Host read strobe; pops the head |
| rd_data_o | output | 8 | FIFO head, or 0 when empty |
| rx_avail_o | output | 1 | FIFO holds at least one byte |

## Verification
The hardest situation to reach is the same-cycle collision of a host read, a flushing command and a key event when the FIFO is nearly full or already wrapped. Random stimulus rarely lines these up.

The bench gets there in two ways:
- Directed steps issue a response command and a key press in one cycle, and a read together with a layout query.
- A long random phase, with a fixed seed, mixes these strobes with lock-key traffic while a bench model of the queue follows every cycle.

Directed fill steps push the FIFO past 16 entries to exercise the drop rule.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  typedef logic [7:0] byte_t;

  localparam byte_t CMD_RESET    = 8'h01;
  localparam byte_t CMD_LED      = 8'h0E;
  localparam byte_t CMD_LAYOUT_A = 8'h07;
  localparam byte_t CMD_LAYOUT_B = 8'h0F;

  localparam byte_t RSP_HDR      = 8'hFF;
  localparam byte_t RSP_TYPE     = 8'h04;
  localparam byte_t RSP_TRAIL    = 8'h7F;
  localparam byte_t RSP_LAYOUT   = 8'hFE;
  localparam byte_t LAYOUT_UNSET = 8'hFF;

  localparam int MAX_RESP = 3;
  localparam int RESP_NW  = $clog2(MAX_RESP + 1);
endpackage

// File: rtl/kbd_cmd_decode.sv
module kbd_cmd_decode
  import kbd_pkg::*;
#(
  parameter byte_t DEF_LAYOUT = 8'h21
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_i,
  input  byte_t                      data_i,
  input  byte_t                      layout_i,
  output logic                       flush_o,
  output logic [RESP_NW-1:0]         resp_n_o,
  output logic [MAX_RESP-1:0][7:0]   resp_o
);
  logic  led_q, led_d;
  byte_t layout_eff;

  assign layout_eff = (layout_i == LAYOUT_UNSET) ? DEF_LAYOUT : layout_i;

  always_comb begin
    led_d    = led_q;
    flush_o  = 1'b0;
    resp_n_o = '0;
    resp_o   = '0;
    if (wr_i) begin
      if (led_q) begin
        led_d = 1'b0;  // LED payload byte: swallow
      end else begin
        unique case (data_i)
          CMD_RESET: begin
            flush_o   = 1'b1;
            resp_n_o  = RESP_NW'(3);
            resp_o[0] = RSP_HDR;
            resp_o[1] = RSP_TYPE;
            resp_o[2] = RSP_TRAIL;
          end
          CMD_LED: led_d = 1'b1;
          CMD_LAYOUT_A, CMD_LAYOUT_B: begin
            flush_o   = 1'b1;
            resp_n_o  = RESP_NW'(2);
            resp_o[0] = RSP_LAYOUT;
            resp_o[1] = layout_eff;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) led_q <= 1'b0;
    else         led_q <= led_d;
  end

  a_r3_led_swallow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && led_q) |-> (resp_n_o == '0 && !flush_o));
  a_r3_led_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && led_q) |=> !led_q);
  a_r2_reset_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !led_q && data_i == CMD_RESET) |-> (flush_o && resp_n_o == RESP_NW'(3)));
  a_r5_default_layout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !led_q && data_i == CMD_LAYOUT_A && layout_i == LAYOUT_UNSET)
      |-> resp_o[1] == DEF_LAYOUT);
endmodule

// File: rtl/kbd_lock_filter.sv
module kbd_lock_filter
  import kbd_pkg::*;
#(
  parameter int N_LOCK = 2,
  localparam int IDX_W = (N_LOCK > 1) ? $clog2(N_LOCK) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic             down_i,
  input  logic [6:0]       code_i,
  input  logic             lock_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             push_o,
  output byte_t            byte_o
);
  logic [1:0] st_q [N_LOCK];
  logic       hit;
  logic [1:0] cur, nxt;
  logic       drop;

  assign hit = evt_i && lock_i && (32'(idx_i) < N_LOCK);

  always_comb begin
    cur = 2'b00;
    for (int i = 0; i < N_LOCK; i++)
      if (32'(idx_i) == i) cur = st_q[i];
  end

  assign nxt    = down_i ? (cur ^ 2'b01) : (cur ^ 2'b10);
  assign drop   = hit && (down_i ? (nxt == 2'b10) : (nxt == 2'b11));
  assign push_o = evt_i && !drop;
  assign byte_o = {~down_i, code_i};

  for (genvar g = 0; g < N_LOCK; g++) begin : g_lock
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             st_q[g] <= 2'b00;
      else if (hit && 32'(idx_i) == g)         st_q[g] <= nxt;
    end
  end

  a_r7_press_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && down_i && cur == 2'b11) |-> !push_o);
  a_r7_release_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !down_i && cur == 2'b01) |-> !push_o);
  a_r6_release_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && !lock_i && !down_i) |-> (push_o && byte_o[7]));
endmodule

// File: rtl/kbd_rx_fifo.sv
module kbd_rx_fifo
  import kbd_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int PUSH_W = 4,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int NW = $clog2(PUSH_W + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   flush_i,
  input  logic [NW-1:0]          push_n_i,
  input  logic [PUSH_W-1:0][7:0] push_data_i,
  input  logic                   pop_i,
  output byte_t                  head_o,
  output logic                   avail_o
);
  byte_t         mem_q [DEPTH];
  logic [PW-1:0] rptr_q, wptr_q, rbase, wbase;
  logic [CW-1:0] cnt_q, c1, room, n_in, n_acc, cnt_d;
  logic          pop_eff, avail_q;

  assign pop_eff = pop_i && (cnt_q != '0) && !flush_i;
  assign c1      = flush_i ? '0 : (cnt_q - CW'(pop_eff));
  assign rbase   = flush_i ? '0 : (rptr_q + PW'(pop_eff));
  assign wbase   = flush_i ? '0 : wptr_q;
  assign room    = CW'(DEPTH) - c1;
  assign n_in    = CW'(push_n_i);
  assign n_acc   = (n_in > room) ? room : n_in;
  assign cnt_d   = c1 + n_acc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q  <= '0;
      wptr_q  <= '0;
      cnt_q   <= '0;
      avail_q <= 1'b0;
    end else begin
      rptr_q  <= rbase;
      wptr_q  <= wbase + PW'(n_acc);
      cnt_q   <= cnt_d;
      avail_q <= (cnt_d != '0);
    end
  end

  always_ff @(posedge clk_i) begin
    for (int k = 0; k < PUSH_W; k++)
      if (CW'(k) < n_acc) mem_q[wbase + PW'(k)] <= push_data_i[k];
  end

  assign head_o  = (cnt_q != '0) ? mem_q[rptr_q] : 8'h00;
  assign avail_o = avail_q;

  a_r8_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CW'(DEPTH) && !flush_i && !pop_i) |=> (cnt_q == CW'(DEPTH) && $stable(wptr_q)));
  a_r9_empty_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && pop_i && !flush_i && push_n_i == '0) |=> (cnt_q == '0 && $stable(rptr_q)));
  a_r10_avail_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avail_o == (cnt_q != '0));
  a_r10_avail_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !flush_i && cnt_q > CW'(1)) |=> avail_o);
  a_r8_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/kbd_responder.sv
module kbd_responder
  import kbd_pkg::*;
#(
  parameter int    FIFO_DEPTH = 16,
  parameter int    N_LOCK     = 2,
  parameter byte_t DEF_LAYOUT = 8'h21,
  localparam int LOCK_IDX_W = (N_LOCK > 1) ? $clog2(N_LOCK) : 1,
  localparam int PUSH_W     = MAX_RESP + 1,
  localparam int PUSH_NW    = $clog2(PUSH_W + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  host_wr_i,
  input  logic [7:0]            host_data_i,
  input  logic [7:0]            layout_i,
  input  logic                  key_evt_i,
  input  logic                  key_down_i,
  input  logic [6:0]            key_code_i,
  input  logic                  key_lock_i,
  input  logic [LOCK_IDX_W-1:0] key_lock_idx_i,
  input  logic                  rd_i,
  output logic [7:0]            rd_data_o,
  output logic                  rx_avail_o
);
  logic                     flush;
  logic [RESP_NW-1:0]       resp_n;
  logic [MAX_RESP-1:0][7:0] resp;
  logic                     key_push;
  byte_t                    key_byte;
  logic [PUSH_NW-1:0]       push_n;
  logic [PUSH_W-1:0][7:0]   push_data;

  kbd_cmd_decode #(.DEF_LAYOUT(DEF_LAYOUT)) i_cmd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (host_wr_i),
    .data_i   (host_data_i),
    .layout_i (layout_i),
    .flush_o  (flush),
    .resp_n_o (resp_n),
    .resp_o   (resp)
  );

  kbd_lock_filter #(.N_LOCK(N_LOCK)) i_lock (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (key_evt_i),
    .down_i (key_down_i),
    .code_i (key_code_i),
    .lock_i (key_lock_i),
    .idx_i  (key_lock_idx_i),
    .push_o (key_push),
    .byte_o (key_byte)
  );

  // response bytes first, key byte right behind them
  always_comb begin
    push_data = '0;
    for (int k = 0; k < MAX_RESP; k++) push_data[k] = resp[k];
    for (int k = 0; k < PUSH_W; k++)
      if (key_push && PUSH_NW'(k) == PUSH_NW'(resp_n)) push_data[k] = key_byte;
    push_n = PUSH_NW'(resp_n) + PUSH_NW'(key_push);
  end

  kbd_rx_fifo #(.DEPTH(FIFO_DEPTH), .PUSH_W(PUSH_W)) i_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush),
    .push_n_i    (push_n),
    .push_data_i (push_data),
    .pop_i       (rd_i),
    .head_o      (rd_data_o),
    .avail_o     (rx_avail_o)
  );

  a_r12_key_after_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_push && resp_n == RESP_NW'(3)) |-> push_data[3] == key_byte);
endmodule

// File: tb/test_kbd_responder.sv
module test_kbd_responder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 0, key_evt = 0, key_down = 0, key_lock = 0, rd = 0;
  logic [7:0] host_data = 0, layout = 8'hFF;
  logic [6:0] key_code = 0;
  logic [0:0] key_idx = 0;
  logic [7:0] rd_data;
  logic       rx_avail;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [7:0] mq[$];
  bit         led_m;
  bit [1:0]   lk_m [2];

  always #5 clk = ~clk;

  kbd_responder i_kbd_responder (
    .clk_i(clk), .rst_ni(rst_n), .host_wr_i(host_wr), .host_data_i(host_data),
    .layout_i(layout), .key_evt_i(key_evt), .key_down_i(key_down),
    .key_code_i(key_code), .key_lock_i(key_lock), .key_lock_idx_i(key_idx),
    .rd_i(rd), .rd_data_o(rd_data), .rx_avail_o(rx_avail)
  );

  function automatic logic [7:0] eff_layout(logic [7:0] l);
    return (l == 8'hFF) ? 8'h21 : l;
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic check_out(input string tag);
    chk(rd_data, (mq.size() != 0) ? mq[0] : 8'h00, {tag, " data"});
    chk({7'd0, rx_avail}, {7'd0, mq.size() != 0}, {tag, " R10 avail"});
  endtask

  task automatic model_apply();
    logic [7:0] pend[$];
    bit fl = 0;
    if (rd && mq.size() != 0) void'(mq.pop_front());
    if (host_wr) begin
      if (led_m) led_m = 0;
      else case (host_data)
        8'h01: begin fl = 1; pend = '{8'hFF, 8'h04, 8'h7F}; end
        8'h0E: led_m = 1;
        8'h07, 8'h0F: begin fl = 1; pend = '{8'hFE, eff_layout(layout)}; end
        default: ;
      endcase
    end
    if (key_evt) begin
      bit drop = 0;
      if (key_lock) begin
        bit [1:0] nw = key_down ? (lk_m[key_idx] ^ 2'b01) : (lk_m[key_idx] ^ 2'b10);
        lk_m[key_idx] = nw;
        drop = key_down ? (nw == 2'b10) : (nw == 2'b11);
      end
      if (!drop) pend.push_back({~key_down, key_code});
    end
    if (fl) mq.delete();
    foreach (pend[i]) if (mq.size() < 16) mq.push_back(pend[i]);
  endtask

  task automatic step(input logic wr, input logic [7:0] d, input logic kv, input logic kd,
                      input logic [6:0] kc, input logic kl, input logic ki, input logic r,
                      input string tag);
    host_wr = wr; host_data = d; key_evt = kv; key_down = kd; key_code = kc;
    key_lock = kl; key_idx = ki; rd = r;
    @(posedge clk);
    model_apply();
    @(negedge clk);
    host_wr = 0; key_evt = 0; rd = 0;
    check_out(tag);
  endtask

  task automatic cmd(input logic [7:0] d, input string tag);
    step(1, d, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic key(input logic dn, input logic [6:0] c, input logic l, input logic i, input string tag);
    step(0, 0, 1, dn, c, l, i, 0, tag);
  endtask
  task automatic rd_exp(input logic [7:0] exp, input string tag);
    chk(rd_data, exp, tag);
    step(0, 0, 0, 0, 0, 0, 0, 1, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_data, 8'h00, "R1 reset data");
    chk({7'd0, rx_avail}, 8'h00, "R1 reset avail");

    // R2
    cmd(8'h01, "R2");
    rd_exp(8'hFF, "R2 byte0"); rd_exp(8'h04, "R2 byte1"); rd_exp(8'h7F, "R2 byte2");
    rd_exp(8'h00, "R9 empty read");
    rd_exp(8'h00, "R9 empty read again");

    // R3: LED byte swallowed even when it looks like a command
    cmd(8'h0E, "R3 enter");
    cmd(8'h01, "R3 swallowed");
    chk({7'd0, rx_avail}, 8'h00, "R3 no response");
    cmd(8'h01, "R3 decode resumes");
    chk(rd_data, 8'hFF, "R3 resumed");

    // R4/R5
    layout = 8'h35;
    cmd(8'h07, "R4 flush and layout");
    rd_exp(8'hFE, "R4 header"); rd_exp(8'h35, "R5 configured layout");
    layout = 8'hFF;
    cmd(8'h0F, "R4 alt");
    rd_exp(8'hFE, "R4 alt header"); rd_exp(8'h21, "R5 default layout");

    // R6
    key(1, 7'h12, 0, 0, "R6 press");
    key(0, 7'h12, 0, 0, "R6 release");
    rd_exp(8'h12, "R6 press code"); rd_exp(8'h92, "R6 release code");

    // R11
    key(1, 7'h05, 0, 0, "R11 preload");
    cmd(8'h55, "R11 unknown");
    rd_exp(8'h05, "R11 queue kept");
    chk({7'd0, rx_avail}, 8'h00, "R11 nothing added");

    // R7: lock on then off -> press, release only
    key(1, 7'h77, 1, 0, "R7 p1"); key(0, 7'h77, 1, 0, "R7 r1");
    key(1, 7'h77, 1, 0, "R7 p2"); key(0, 7'h77, 1, 0, "R7 r2");
    rd_exp(8'h77, "R7 first press"); rd_exp(8'hF7, "R7 second release");
    chk({7'd0, rx_avail}, 8'h00, "R7 two dropped");
    key(1, 7'h62, 1, 1, "R7 lock1 press");
    rd_exp(8'h62, "R7 lock1 independent");

    // R12: response then key in one cycle
    step(1, 8'h01, 1, 1, 7'h33, 0, 0, 0, "R12 cmd+key");
    rd_exp(8'hFF, "R12 b0"); rd_exp(8'h04, "R12 b1"); rd_exp(8'h7F, "R12 b2");
    rd_exp(8'h33, "R12 key last");
    key(1, 7'h40, 0, 0, "R12 preload");
    chk(rd_data, 8'h40, "R12 head before flush");
    step(1, 8'h07, 0, 0, 0, 0, 0, 1, "R12 read+flush");
    rd_exp(8'hFE, "R12 after flush"); rd_exp(8'h21, "R12 layout");

    // R8/R13: overfill
    for (int i = 0; i < 18; i++) key(1, 7'(i + 1), 0, 0, "R8 fill");
    for (int i = 0; i < 16; i++) rd_exp(8'(i + 1), "R13 order");
    rd_exp(8'h00, "R8 extras dropped");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] d;
      int sel = $urandom_range(0, 9);
      case ($urandom_range(0, 4))
        0: d = 8'h01; 1: d = 8'h0E; 2: d = 8'h07; 3: d = 8'h0F; default: d = 8'($urandom);
      endcase
      if ($urandom_range(0, 3) == 0) layout = ($urandom_range(0, 1) != 0) ? 8'hFF : 8'($urandom);
      step(sel == 0, d, $urandom_range(0, 1) != 0, $urandom_range(0, 1) != 0,
           7'($urandom), $urandom_range(0, 2) == 0, 1'($urandom), $urandom_range(0, 9) < 4,
           "R13 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule